// File: doc/BRIEF.md
# Ring-Oscillator Thermal Channel

This block controls one channel of an on-die temperature sensor. A period timer in the reference clock domain opens a counting window every M reference cycles. The window lasts N reference cycles. During the window the block adds up oscillator edges into a saturating 16-bit counter. A hotter die makes the ring oscillator run faster, so a larger count means a higher temperature.

When a window closes, the count is latched and compared with three programmable thresholds. The comparison gives a thermal state code. That code drives three hardware action requests (DVFS, clock halving and emergency reset) and can set a level-triggered interrupt on upward crossings. A front end outside the block counts the oscillator edges that fall in each reference cycle and presents that number on `osc_edges`.

Software reaches the block through a flat word-indexed register port with an immediate read path. Index 0 is config word 0, index 1 holds thresholds 1 and 2, index 2 holds threshold 3, index 3 is the status word and index 4 is the count word. Software parks the channel with the stop bit.

Top module: `thermo_ring_chan`

## Requirements
- R1: After reset every register reads zero, `irq` is low and all three action requests are low.
- R2: A window starts only while the stop bit (config 0 bit 0) is clear and both M (config 0 bits 23:8) and N (config 0 bits 31:24) are nonzero. With M or N at zero the valid flag (status bit 9) stays low.
- R3: A window sums `osc_edges` over exactly N reference cycles and saturates at 0xFFFF. The result appears in count word bits 31:16. The valid flag rises when the first window closes and then stays high while the channel runs.
- R4: Status bits 2:0 hold the state code. The code is the highest level whose threshold the count meets or exceeds, with comparison by greater-or-equal. Threshold 1 is config 1 bits 15:0, threshold 2 is config 1 bits 31:16 and threshold 3 is config 2 bits 15:0. The code is 0 when no threshold is met, and 5 when the count is 0xFFFF.
- R5: `dvfs_req` = config 0 bit 3 and level ≥ 1. `clkdiv_req` = config 0 bit 1 and level ≥ 2. `therm_rst_req` = config 0 bit 2 and level ≥ 3. Code 5 ranks above level 3.
- R6: A closing window that raises the rank past a level sets the pending flag (status bit 8), and `irq` follows that flag. Each level has its own enable: level 1 uses config 0 bit 3, level 2 uses bit 5, level 3 uses bit 6 and overflow (code 5) uses bit 4.
- R7: A drop in level never sets the pending flag.
- R8: A write to the status index with bit 8 set clears the pending flag. A write with bit 8 clear leaves it unchanged.
- R9: Setting the stop bit pulls all action requests low at once. It clears the state code and the valid flag on the next edge. It lets the window in progress finish, and it starts no new windows.
- R10: Config words read back as written, except that config 0 bit 7 always reads 0. Writes to the count index have no effect.
- R11: A period tick that arrives while a window is still open is skipped, so every window counts a full N cycles even when M < N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_edges | input | OSC_W | Oscillator edges seen in this reference cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dvfs_req | output | 1 | Level-1 DVFS cooling request |
| clkdiv_req | output | 1 | Level-2 clock halving request |
| therm_rst_req | output | 1 | Level-3 emergency reset request |
| irq | output | 1 | Level interrupt, mirrors the pending flag |

## Verification
The bench targets the following corner cases:
- A count exactly equal to a threshold. A design that compares with strict greater-than would report one level too low.
- A window that saturates. A design that wraps instead of saturating would show a small count and a cold state rather than code 5 with every action raised.
- A period shorter than the window. A design that restarts the window on each tick would report a truncated count.
- A falling temperature with all interrupts enabled. A design that fires on any level change would raise `irq` there.
- A status write with bit 8 clear. A design that clears the pending flag on any status write would drop it.
- Stopping a running channel. A design that ignores stop would keep raising requests and refreshing the count after the channel is parked.

// File: rtl/thermo_ring_chan.sv
module thermo_ring_chan #(
  parameter int OSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OSC_W-1:0] osc_edges,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             dvfs_req,
  output logic             clkdiv_req,
  output logic             therm_rst_req,
  output logic             irq
);

  localparam logic [2:0]  ST_OVF  = 3'd5;
  localparam logic [15:0] CNT_MAX = 16'hFFFF;

  function automatic logic [2:0] rank_of(input logic [2:0] code);
    return (code == ST_OVF) ? 3'd4 : code;
  endfunction

  logic [31:0] cfg0_q, cfg1_q, cfg2_q;
  logic [15:0] per_q, acc_q, cnt_q;
  logic [7:0]  wc_q;
  logic        busy_q, valid_q, pend_q;
  logic [2:0]  st_q;

  logic        stop, run, start, in_win, done, evt, clr;
  logic [15:0] per_m, acc_base, acc_nxt;
  logic [7:0]  win_n, wc_base;
  logic [16:0] sum;
  logic [2:0]  new_code, new_rank, old_rank, cur_rank;

  assign stop  = cfg0_q[0];
  assign per_m = cfg0_q[23:8];
  assign win_n = cfg0_q[31:24];
  assign run   = !stop && per_m != 16'd0 && win_n != 8'd0;

  assign start    = run && per_q == 16'd0 && !busy_q;
  assign in_win   = busy_q || start;
  assign acc_base = start ? 16'd0 : acc_q;
  assign sum      = {1'b0, acc_base} + 17'(osc_edges);
  assign acc_nxt  = sum[16] ? CNT_MAX : sum[15:0];
  assign wc_base  = start ? 8'd0 : wc_q;
  assign done     = in_win && (wc_base == win_n - 8'd1);

  always_comb begin
    if (acc_nxt == CNT_MAX)          new_code = ST_OVF;
    else if (acc_nxt >= cfg2_q[15:0])  new_code = 3'd3;
    else if (acc_nxt >= cfg1_q[31:16]) new_code = 3'd2;
    else if (acc_nxt >= cfg1_q[15:0])  new_code = 3'd1;
    else                               new_code = 3'd0;
  end

  assign new_rank = rank_of(new_code);
  assign old_rank = rank_of(st_q);
  assign cur_rank = old_rank;

  assign evt = done && !stop &&
               ((new_rank >= 3'd1 && old_rank < 3'd1 && cfg0_q[3]) ||
                (new_rank >= 3'd2 && old_rank < 3'd2 && cfg0_q[5]) ||
                (new_rank >= 3'd3 && old_rank < 3'd3 && cfg0_q[6]) ||
                (new_rank == 3'd4 && old_rank < 3'd4 && cfg0_q[4]));
  assign clr = reg_wr && reg_addr == 3'd3 && reg_wdata[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      cfg2_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0:    cfg0_q <= reg_wdata & 32'hFFFF_FF7F;
        3'd1:    cfg1_q <= reg_wdata;
        3'd2:    cfg2_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  per_q <= '0;
    else if (!run)               per_q <= '0;
    else if (per_q >= per_m - 16'd1) per_q <= '0;
    else                         per_q <= per_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      acc_q  <= '0;
      wc_q   <= '0;
    end else if (in_win) begin
      busy_q <= !done;
      acc_q  <= acc_nxt;
      wc_q   <= wc_base + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      st_q    <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (done) cnt_q <= acc_nxt;
      if (stop) begin
        st_q    <= '0;
        valid_q <= 1'b0;
      end else if (done) begin
        st_q    <= new_code;
        valid_q <= 1'b1;
      end
      if (evt)      pend_q <= 1'b1;
      else if (clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = cfg0_q;
      3'd1:    reg_rdata = cfg1_q;
      3'd2:    reg_rdata = cfg2_q;
      3'd3:    reg_rdata = {22'd0, valid_q, pend_q, 5'd0, st_q};
      3'd4:    reg_rdata = {cnt_q, 16'd0};
      default: reg_rdata = '0;
    endcase
  end

  assign dvfs_req      = !stop && cfg0_q[3] && cur_rank >= 3'd1;
  assign clkdiv_req    = !stop && cfg0_q[1] && cur_rank >= 3'd2;
  assign therm_rst_req = !stop && cfg0_q[2] && cur_rank >= 3'd3;
  assign irq           = pend_q;

endmodule

// File: rtl/thermo_ring_chan_chk.sv
module thermo_ring_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stop,
  input logic        cfg_idle,
  input logic        busy,
  input logic        done,
  input logic        valid,
  input logic        pend,
  input logic [2:0]  st,
  input logic [15:0] cnt
);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == 3'd0 && !valid));

  p_valid_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !stop) |=> valid);

  p_ovf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd5) |-> (cnt == 16'hFFFF));

  p_pend_from_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(done));

  p_no_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_idle) |=> !busy);

endmodule

bind thermo_ring_chan thermo_ring_chan_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop     (cfg0_q[0]),
  .cfg_idle (!run),
  .busy     (busy_q),
  .done     (done),
  .valid    (valid_q),
  .pend     (pend_q),
  .st       (st_q),
  .cnt      (cnt_q)
);

// File: tb/thermo_ring_chan_tb_top.sv
module thermo_ring_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  osc_edges = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dvfs_req, clkdiv_req, therm_rst_req, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  always #10 clk = ~clk;

  thermo_ring_chan #(.OSC_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_edges(osc_edges),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dvfs_req(dvfs_req), .clkdiv_req(clkdiv_req),
    .therm_rst_req(therm_rst_req), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_valid(output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd3, s);
      if (s[9]) begin ok = 1'b1; break; end
    end
  endtask

  function automatic int exp_count(input int e, input int n);
    int p = e * n;
    return (p > 65535) ? 65535 : p;
  endfunction

  function automatic logic [2:0] exp_code(input int c, input int t1, input int t2, input int t3);
    if (c == 65535) return 3'd5;
    if (c >= t3) return 3'd3;
    if (c >= t2) return 3'd2;
    if (c >= t1) return 3'd1;
    return 3'd0;
  endfunction

  function automatic int rank(input logic [2:0] c);
    return (c == 3'd5) ? 4 : int'(c);
  endfunction

  // ctl[0]=div_en(b1) ctl[1]=rst_en(b2) ctl[2]=dvfs_en(b3) ctl[3]=ovf_ie(b4) ctl[4]=div_ie(b5) ctl[5]=rst_ie(b6)
  function automatic logic [31:0] cfg0_word(input int n, input int m, input logic [5:0] ctl, input bit stp);
    return {n[7:0], m[15:0], 1'b0, ctl, stp};
  endfunction

  task automatic run_case(input string req, input int e, input int n, input int m,
                          input int t1, input int t2, input int t3, input logic [5:0] ctl);
    logic [31:0] s, c;
    bit ok;
    int cnt, r;
    logic [2:0] code;
    bit ei;
    wr(3'd0, 32'h1);
    repeat (300) @(negedge clk);
    osc_edges = e[9:0];
    wr(3'd1, {t2[15:0], t1[15:0]});
    wr(3'd2, {16'd0, t3[15:0]});
    wr(3'd3, 32'h100);
    wr(3'd0, cfg0_word(n, m, ctl, 1'b0));
    wait_valid(ok);
    check(req, "valid rises", {31'd0, ok}, 32'd1);
    cnt  = exp_count(e, n);
    code = exp_code(cnt, t1, t2, t3);
    r    = rank(code);
    ei   = (r >= 1 && ctl[2]) || (r >= 2 && ctl[4]) || (r >= 3 && ctl[5]) || (r == 4 && ctl[3]);
    rd(3'd4, c);
    check(req, "count", {16'd0, c[31:16]}, cnt);
    rd(3'd3, s);
    check(req, "state", {29'd0, s[2:0]}, {29'd0, code});
    check(req, "irq", {31'd0, irq}, {31'd0, ei});
    check(req, "dvfs_req", {31'd0, dvfs_req}, {31'd0, ctl[2] && r >= 1});
    check(req, "clkdiv_req", {31'd0, clkdiv_req}, {31'd0, ctl[0] && r >= 2});
    check(req, "therm_rst_req", {31'd0, therm_rst_req}, {31'd0, ctl[1] && r >= 3});
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got expired expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], d);
      check("R1", "reg after reset", d, 32'd0);
    end
    check("R1", "outputs after reset", {28'd0, dvfs_req, clkdiv_req, therm_rst_req, irq}, 32'd0);

    // R10 readback and ignored count write
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R10", "cfg0 readback", d, 32'hFFFF_FF7F);
    wr(3'd1, 32'hA5C3_1E77);
    rd(3'd1, d); check("R10", "cfg1 readback", d, 32'hA5C3_1E77);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, d); check("R10", "count write ignored", d, 32'd0);
    wr(3'd1, 32'd0);

    // R2 no windows with M or N zero
    osc_edges = 10'd5;
    wr(3'd0, cfg0_word(10, 0, 6'd0, 1'b0));
    repeat (300) @(negedge clk);
    rd(3'd3, d); check("R2", "valid with M=0", {31'd0, d[9]}, 32'd0);
    wr(3'd0, cfg0_word(0, 10, 6'd0, 1'b0));
    repeat (300) @(negedge clk);
    rd(3'd3, d); check("R2", "valid with N=0", {31'd0, d[9]}, 32'd0);
    rd(3'd4, d); check("R2", "count untouched", d, 32'd0);

    // R4 equality boundary
    run_case("R4", 10, 10, 20, 100, 101, 200, 6'b000100);

    // R11 period shorter than window
    run_case("R11", 7, 20, 3, 1000, 2000, 3000, 6'd0);

    // R4 R5 R6 overflow with only overflow interrupt enabled
    run_case("R6", 1023, 100, 120, 16'hF000, 16'hF100, 16'hF200, 6'b001011);
    // R6 overflow with interrupt gated off
    run_case("R6", 1023, 100, 120, 16'hF000, 16'hF100, 16'hF200, 6'b000011);

    // R3 R4 R5 R6 random
    for (int k = 0; k < 24; k++) begin
      int e, n, m, c, t1, t2, t3;
      e = $urandom_range(0, 1023);
      n = $urandom_range(1, 40);
      m = n + $urandom_range(0, 30);
      c = exp_count(e, n);
      t1 = $urandom_range(0, 2 * c + 2);
      t2 = $urandom_range(0, 2 * c + 2);
      t3 = $urandom_range(0, 2 * c + 2);
      if (t1 > 65535) t1 = 65535;
      if (t2 > 65535) t2 = 65535;
      if (t3 > 65535) t3 = 65535;
      run_case("R3", e, n, m, t1, t2, t3, 6'($urandom_range(0, 63)));
    end

    // R7 R8 falling and clearing
    run_case("R6", 100, 50, 60, 1000, 2000, 3000, 6'b111111);
    wr(3'd3, 32'h0);
    check("R8", "write without bit8 keeps irq", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'h100);
    check("R8", "write with bit8 clears irq", {31'd0, irq}, 32'd0);
    osc_edges = 10'd30;
    repeat (400) @(negedge clk);
    rd(3'd3, d);
    check("R7", "state after fall", {29'd0, d[2:0]}, 32'd1);
    check("R7", "no irq on fall", {31'd0, irq}, 32'd0);
    check("R5", "actions after fall", {29'd0, dvfs_req, clkdiv_req, therm_rst_req}, 32'b100);
    osc_edges = 10'd100;
    repeat (400) @(negedge clk);
    rd(3'd3, d);
    check("R6", "state after rise", {29'd0, d[2:0]}, 32'd3);
    check("R6", "irq on rise", {31'd0, irq}, 32'd1);

    // R9 stop
    wr(3'd0, cfg0_word(50, 60, 6'b111111, 1'b1));
    check("R9", "actions low on stop", {29'd0, dvfs_req, clkdiv_req, therm_rst_req}, 32'd0);
    rd(3'd3, d);
    check("R9", "state cleared", {29'd0, d[2:0]}, 32'd0);
    check("R9", "valid cleared", {31'd0, d[9]}, 32'd0);
    repeat (200) @(negedge clk);
    osc_edges = 10'd1;
    repeat (400) @(negedge clk);
    rd(3'd4, d);
    check("R9", "no new window while stopped", {16'd0, d[31:16]}, 32'd5000);
    rd(3'd3, d);
    check("R9", "valid stays low", {31'd0, d[9]}, 32'd0);

    fin = 1'b1;
    summary();
    $finish;
  end

endmodule